// File: doc/BRIEF.md
# SPI Controller with Timed Chip Select

This block runs byte transfers from a fast system clock to an external SPI peripheral, such as a serial EEPROM. It derives the serial clock from the system clock by an even divider. It drives an active-low chip select whose setup delay, hold delay and idle interval are counted in system clock cycles. Bits are shifted out and in most significant bit first. Every transfer opens with a header byte that holds a 7-bit peripheral address and a direction flag, and then carries 1 to 16 data bytes under the same select.

A command port captures the address, direction and byte count on a start pulse. On a write, each data byte is read from `wdata` at the moment it is loaded into the shifter. A one-cycle `wr_take` strobe follows, so the host can present the next byte. On a read, each received byte appears on `rd_data` with a one-cycle `rd_valid` strobe. A `done` pulse closes the transfer. The data output has its own enable, which drops after the final serial clock falling edge.

Top module: `spi_cs_master`

## Requirements
- R1: The serial clock period is CLK_DIV system clocks (CLK_DIV even, at least 2), high for CLK_DIV/2 and low for CLK_DIV/2. The serial clock is low whenever `cs_n` is high.
- R2: The first rising serial clock edge comes exactly LEAD_CYC + CLK_DIV/2 system clocks after `cs_n` falls.
- R3: `cs_n` rises exactly LEAD_CYC + CLK_DIV/2 system clocks after the last falling serial clock edge.
- R4: `done` pulses for one cycle exactly GAP_CYC cycles after `cs_n` rises. `busy` is high from acceptance until that cycle and is low while `done` is high, so consecutive selects are separated by at least GAP_CYC high cycles.
- R5: The first byte sent is {dev_addr[6:0], rd_req}, with the address in bits 7..1 and the flag in bit 0, sent MSB first. `mosi` changes only together with a falling serial clock edge.
- R6: With `rd_req`=0, `byte_cnt_m1`+1 data bytes follow the header byte, each taken from `wdata`. Exactly one `wr_take` strobe occurs per data byte.
- R7: With `rd_req`=1, data bytes drive `mosi` low. `miso` is sampled at each rising serial clock edge. Each of the `byte_cnt_m1`+1 received bytes (MSB first) appears on `rd_data` with a one-cycle `rd_valid` strobe. No strobe occurs for the header byte.
- R8: `mosi_oe` is high from the `cs_n` falling edge until the last falling serial clock edge of the transfer, and low otherwise.
- R9: A `start` pulse while `busy` is high is ignored: it produces no extra select, and it does not change the running transfer's address, direction or byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, accepted only while idle |
| rd_req | input | 1 | Direction flag, 1 = read |
| dev_addr | input | 7 | Peripheral address for the header byte |
| byte_cnt_m1 | input | $clog2(MAX_BYTES) | Data byte count minus one |
| wdata | input | 8 | Next write data byte |
| wr_take | output | 1 | Strobe: `wdata` was just consumed |
| rd_data | output | 8 | Last received data byte |
| rd_valid | output | 1 | Strobe: `rd_data` holds a new byte |
| busy | output | 1 | Transfer in progress, including the idle gap |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |

## Verification
Two situations are hard to reach from the ports. One is a new start request that lands in the middle of a running transfer while the command fields change. The other is the last bit of a full 16-byte burst, where the byte counter, the data enable and the lag timer all turn over on one edge. The bench sweeps every byte count in both directions, back to back. On selected transfers it pulses `start` partway through with different address, direction and count, and it checks that exactly one select occurred and that the header still matches the first command. A bit-level peripheral model in the bench answers each transfer with a computed pattern and times every edge in system cycles.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_LAG,
    ST_GAP
  } xfer_state_t;

  // Cycles between select fall and first rise, and between last fall and select rise.
  function automatic int unsigned edge_wait(input int unsigned lead, input int unsigned div);
    return lead + div / 2;
  endfunction

  // Header byte: address in bits 7..1, direction in bit 0.
  function automatic logic [7:0] head_byte(input logic [6:0] addr, input logic rd);
    return {addr, rd};
  endfunction

endpackage

// File: rtl/spi_cs_sclk.sv
module spi_cs_sclk #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_now,
  output logic fall_now
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [PW-1:0] ph;

  // Phase parks at the last slot, so the first cycle of run rises at once.
  assign rise_now = run && (ph == PW'(CLK_DIV - 1));
  assign fall_now = run && (ph == PW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PW'(CLK_DIV - 1);
      sclk <= 1'b0;
    end else if (!run) begin
      ph   <= PW'(CLK_DIV - 1);
      sclk <= 1'b0;
    end else begin
      ph <= rise_now ? '0 : ph + PW'(1);
      if (rise_now)      sclk <= 1'b1;
      else if (fall_now) sclk <= 1'b0;
    end
  end

  // R1: a rise only ever follows a low clock
  p_rise_from_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_now |-> !sclk);

endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       rise,
  input  logic       fall,
  input  logic       miso,
  output logic       mosi_bit,
  output logic [2:0] bit_idx,
  output logic       last_bit,
  output logic [7:0] rx_next
);
  logic [7:0] tx;
  logic [7:0] rx;

  assign mosi_bit = tx[7];
  assign last_bit = (bit_idx == 3'd7);
  assign rx_next  = {rx[6:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx      <= '0;
      rx      <= '0;
      bit_idx <= '0;
    end else begin
      if (load) begin
        tx      <= load_val;
        bit_idx <= '0;
      end else if (fall) begin
        tx      <= {tx[6:0], 1'b0};
        bit_idx <= bit_idx + 3'd1;
      end
      if (rise) rx <= rx_next;
    end
  end

  // R5: new data never lands on a rising edge
  p_load_off_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !rise);

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int LEAD_CYC  = 11,
  parameter int GAP_CYC   = 3,
  parameter int MAX_BYTES = 16,
  localparam int NW = (MAX_BYTES > 2) ? $clog2(MAX_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_req,
  input  logic [6:0]    dev_addr,
  input  logic [NW-1:0] byte_cnt_m1,
  input  logic [7:0]    wdata,
  output logic          wr_take,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic          cs_n,
  output logic          sclk,
  output logic          mosi,
  output logic          mosi_oe,
  input  logic          miso
);
  localparam int EDGE_WAIT = edge_wait(LEAD_CYC, CLK_DIV);
  localparam int BW        = $clog2(MAX_BYTES + 1);
  localparam int TW        = $clog2(EDGE_WAIT + GAP_CYC + 2) + 1;

  xfer_state_t   state;
  logic [TW-1:0] tmr;
  logic          lat_rd;
  logic [BW-1:0] lat_last;
  logic [BW-1:0] byte_no;

  logic       accept, lead_end, run, rise_now, fall_now;
  logic       final_fall, next_load, load, last_bit, mosi_bit;
  logic [2:0] bit_idx;
  logic [7:0] load_val, rx_next;

  assign busy       = (state != ST_IDLE);
  assign accept     = (state == ST_IDLE) && start;
  assign lead_end   = (state == ST_LEAD) && (tmr == TW'(EDGE_WAIT - 1));
  assign run        = (state == ST_SHIFT) || lead_end;
  assign final_fall = fall_now && last_bit && (byte_no == lat_last);
  assign next_load  = fall_now && last_bit && !final_fall;
  assign load       = accept || next_load;
  assign load_val   = accept ? head_byte(dev_addr, rd_req) : (lat_rd ? 8'h00 : wdata);
  assign mosi       = mosi_oe & mosi_bit;

  spi_cs_sclk #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sclk     (sclk),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  spi_cs_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .rise     (rise_now),
    .fall     (fall_now),
    .miso     (miso),
    .mosi_bit (mosi_bit),
    .bit_idx  (bit_idx),
    .last_bit (last_bit),
    .rx_next  (rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      lat_rd   <= 1'b0;
      lat_last <= '0;
      byte_no  <= '0;
      cs_n     <= 1'b1;
      mosi_oe  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_LEAD;
          tmr      <= '0;
          cs_n     <= 1'b0;
          mosi_oe  <= 1'b1;
          lat_rd   <= rd_req;
          lat_last <= BW'(byte_cnt_m1) + BW'(1);
          byte_no  <= '0;
        end
        ST_LEAD: begin
          if (lead_end) state <= ST_SHIFT;
          else          tmr   <= tmr + TW'(1);
        end
        ST_SHIFT: begin
          if (rise_now && last_bit && (byte_no != '0) && lat_rd) begin
            rd_data  <= rx_next;
            rd_valid <= 1'b1;
          end
          if (next_load) begin
            byte_no <= byte_no + BW'(1);
            wr_take <= !lat_rd;
          end
          if (final_fall) begin
            state   <= ST_LAG;
            tmr     <= '0;
            mosi_oe <= 1'b0;
          end
        end
        ST_LAG: begin
          if (tmr == TW'(EDGE_WAIT - 1)) begin
            cs_n  <= 1'b1;
            state <= ST_GAP;
            tmr   <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_GAP: begin
          if (tmr == TW'(GAP_CYC - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Observation counters that feed the assertions only.
  logic [TW-1:0] since_evt;
  logic [TW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_evt <= '0;
      hi_cnt    <= '0;
    end else begin
      if (accept || fall_now)    since_evt <= '0;
      else if (since_evt != '1)  since_evt <= since_evt + TW'(1);
      if (!cs_n)                 hi_cnt <= '0;
      else if (hi_cnt != '1)     hi_cnt <= hi_cnt + TW'(1);
    end
  end

  p_sclk_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_lead_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && byte_no == '0 && bit_idx == 3'd0) |-> since_evt >= TW'(EDGE_WAIT));

  p_lag_time_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> since_evt >= TW'(EDGE_WAIT));

  p_gap_before_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hi_cnt >= TW'(GAP_CYC)) && !busy);

  p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mosi_oe && $past(mosi_oe) && !$stable(mosi)) |-> $fell(sclk));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_oe_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi_oe);

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(lat_last) && $stable(lat_rd));

endmodule

// File: tb/test_spi_cs_master.sv
module test_spi_cs_master;
  localparam int DIV  = 4;
  localparam int LEAD = 11;
  localparam int GAP  = 3;
  localparam int MAXB = 16;
  localparam int H    = DIV / 2;
  localparam int EW   = LEAD + H;
  localparam int NBIT = 8 * (MAXB + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       rd_req = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [3:0] byte_cnt_m1 = '0;
  logic [7:0] wdata;
  logic       wr_take, rd_valid, busy, done, cs_n, sclk, mosi, mosi_oe;
  logic [7:0] rd_data;
  logic       miso = 1'b0;

  always #4 clk = ~clk;

  spi_cs_master #(.CLK_DIV(DIV), .LEAD_CYC(LEAD), .GAP_CYC(GAP), .MAX_BYTES(MAXB)) i_spi_cs_master (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .dev_addr(dev_addr),
    .byte_cnt_m1(byte_cnt_m1), .wdata(wdata), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
  );

  int checks = 0;
  int fails  = 0;
  int seed   = 0;
  int n_take = 0;

  function automatic logic [7:0] wbyte(input int s, input int k);
    return 8'((s ^ (k * 29 + 5)) & 255);
  endfunction
  function automatic logic [7:0] mbyte(input int s, input int j);
    return 8'((s * 11 + j * 37 + 3) & 255);
  endfunction
  function automatic logic mbit(input int s, input int b);
    logic [7:0] v;
    v = mbyte(s, b / 8);
    return v[7 - (b % 8)];
  endfunction

  assign wdata = wbyte(seed, n_take);

  // Monitor and peripheral model state
  int cyc = 0, t_csf = 0, t_r1 = 0, t_lr = 0, t_lf = 0, t_csr = 0, t_prev_csr = -1000;
  int gap_seen = 0, per_err = 0, oe_err = 0, busy_err = 0;
  int n_rise = 0, n_fall = 0, n_rd = 0, n_csf = 0, exp_bits = 8;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  logic [0:NBIT-1] bits;
  logic [7:0] rdq [0:MAXB-1];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (prev_cs && !cs_n) begin
        t_csf = cyc; n_rise = 0; n_fall = 0; n_csf++;
        miso = mbit(seed, 0);
        if (!busy) busy_err++;
        if (t_csf - t_prev_csr < GAP) busy_err++;
      end
      if (!prev_sclk && sclk) begin
        if (n_rise == 0) t_r1 = cyc;
        else if (cyc - t_lr != DIV) per_err++;
        t_lr = cyc;
        if (n_rise < NBIT) bits[n_rise] = mosi;
        n_rise++;
      end
      if (prev_sclk && !sclk) begin
        if (cyc - t_lr != H) per_err++;
        t_lf = cyc; n_fall++;
        miso = mbit(seed, n_fall);
      end
      if (sclk && cs_n) per_err++;
      if (!prev_cs && cs_n) begin t_csr = cyc; t_prev_csr = cyc; end
      if (rd_valid) begin
        if (n_rd < MAXB) rdq[n_rd] = rd_data;
        n_rd++;
      end
      if (wr_take) n_take++;
      if (done) begin
        gap_seen = cyc - t_csr;
        if (busy) busy_err++;
      end
      if (mosi_oe != (!cs_n && n_fall < exp_bits)) oe_err++;
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic xfer(input logic [6:0] a, input logic r, input int nm1, input int s, input bit poke);
    int guard;
    logic [7:0] got;
    int bad;
    @(negedge clk);
    seed = s; n_take = 0; n_rd = 0; n_csf = 0; per_err = 0; oe_err = 0; busy_err = 0;
    exp_bits = 8 * (nm1 + 2);
    dev_addr = a; rd_req = r; byte_cnt_m1 = 4'(nm1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      dev_addr = ~a; rd_req = ~r; byte_cnt_m1 = 4'(15 - nm1); start = 1'b1;
      @(negedge clk);
      start = 1'b0; dev_addr = a; rd_req = r; byte_cnt_m1 = 4'(nm1);
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, "R4 done timeout", guard, 0);
    @(negedge clk);
    chk(per_err == 0, "R1 sclk period/idle", per_err, 0);
    chk(t_r1 - t_csf == EW, "R2 lead", t_r1 - t_csf, EW);
    chk(t_csr - t_lf == EW, "R3 lag", t_csr - t_lf, EW);
    chk(gap_seen == GAP && busy_err == 0, "R4 gap/busy", gap_seen, GAP);
    for (int i = 0; i < 8; i++) got[7 - i] = bits[i];
    chk(got == {a, r}, "R5 header", int'(got), int'({a, r}));
    chk(n_rise == exp_bits, "R6 bit count", n_rise, exp_bits);
    bad = 0;
    for (int j = 0; j <= nm1; j++) begin
      for (int i = 0; i < 8; i++) got[7 - i] = bits[8 * (j + 1) + i];
      if (got != (r ? 8'h00 : wbyte(s, j))) bad++;
    end
    chk(bad == 0, r ? "R7 mosi zero on read" : "R6 write bytes", bad, 0);
    chk(n_take == (r ? 0 : nm1 + 1), "R6 take strobes", n_take, r ? 0 : nm1 + 1);
    chk(n_rd == (r ? nm1 + 1 : 0), "R7 rd strobes", n_rd, r ? nm1 + 1 : 0);
    bad = 0;
    if (r) for (int j = 0; j <= nm1 && j < MAXB; j++) if (rdq[j] != mbyte(s, j + 1)) bad++;
    chk(bad == 0, "R7 read bytes", bad, 0);
    chk(oe_err == 0, "R8 mosi_oe window", oe_err, 0);
    if (poke) chk(n_csf == 1, "R9 start ignored while busy", n_csf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset idle lines", {cs_n, sclk}, 2);
    chk(busy == 1'b0 && done == 1'b0, "R4 reset busy/done", {busy, done}, 0);
    chk(mosi_oe == 1'b0, "R8 reset oe", mosi_oe, 0);
    rst_n = 1'b1;
    for (int r = 0; r < 2; r++)
      for (int n = 0; n < MAXB; n++)
        xfer(7'((n * 9 + r * 40 + 1) & 127), r[0], n, n * 17 + r * 5 + 1, (n % 5) == 2);
    xfer(7'h7F, 1'b1, 15, 200, 1'b1);
    xfer(7'h00, 1'b0, 15, 77, 1'b0);
    xfer(7'h55, 1'b0, 0, 3, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule